// File: doc/BRIEF.md
# Amplifier Protection Fault Supervisor

This block watches the digital protection flags of an audio power stage and decides two things: whether the output bridge may drive, and whether the active-low fault indicator is pulled down. Its inputs are five condition flags (overcurrent, overtemperature, DC offset at the output, supply undervoltage, supply overvoltage) and a run request that works like a shutdown pin. Its outputs are a drive enable for the bridge, the fault indicator, and a status word.

Faults come in two classes. Overcurrent, overtemperature and DC offset are sticky: once seen, they hold the bridge off and pull the fault indicator low after the condition has gone. The only way out is to drop the run request. The supply faults only hold the bridge off while they last, and they leave the fault indicator alone. The status word names the sticky fault that fired first, shows which sticky faults are held, and shows the live supply flags.

If the fault indicator is wired back onto the run request, a sticky fault removes its own run request, clears itself and lets the stage start again. This gives a self-retrying amplifier. All flags, including the run request, pass through two-flop synchronizers. This block has no streaming data, so every pin is a plain level.

Top module: `amp_fault_supervisor`

## Requirements
- R1: An overcurrent, overtemperature or DC-offset flag seen while running drives `fault_n` low and `out_en` low, and both stay that way after the flag drops.
- R2: An undervoltage or overvoltage flag forces `out_en` low only while it is present. It never pulls `fault_n` low, and `out_en` returns by itself once the flag clears.
- R3: Sticky faults and the first-cause field clear only while the synchronized run request is low. A low level held for one clock is enough.
- R4: While the run request is low, `out_en` is low.
- R5: `out_en` is high only when the run request is high, no sticky fault is held and no fault flag of either class is present.
- R6: If a sticky condition is still present when the run request returns high, the fault sets again on the following clock.
- R7: `status[6:5]` gives the first sticky cause: 0 none, 1 overcurrent, 2 overtemperature, 3 DC offset. When several appear in the same cycle, overcurrent wins over overtemperature, and overtemperature wins over DC offset. The field does not change until it is cleared.
- R8: `status[4]`, `status[3]` and `status[2]` show the held overcurrent, overtemperature and DC-offset faults. `status[1]` and `status[0]` show the synchronized undervoltage and overvoltage flags.
- R9: An input change reaches the logic after two clock edges. A fault flag drops `out_en` after the second edge and `fault_n` after the third.
- R10: With `fault_n` looped onto the run request, a single-cycle sticky fault clears itself, and the block returns to `fault_n` high with `out_en` high.
- R11: During and after reset, `out_en` is low, `fault_n` is high and `status` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_req | input | 1 | Run request; low means shutdown and clears sticky faults |
| oc_flag | input | 1 | Overcurrent condition |
| ot_flag | input | 1 | Overtemperature condition |
| dc_flag | input | 1 | Output DC-offset condition |
| uv_flag | input | 1 | Supply undervoltage condition |
| ov_flag | input | 1 | Supply overvoltage condition |
| out_en | output | 1 | Bridge drive enable; low means outputs high impedance |
| fault_n | output | 1 | Active-low sticky fault indicator |
| status | output | 7 | First cause, held sticky faults and live supply flags |

## Verification
The main table goes through four kinds of pattern: each supply flag alone, to show it self-clears without touching `fault_n`; each sticky flag alone, to show it holds after removal; a second sticky flag arriving after a first, to show the first-cause field does not move; and a release of the run request with the sticky condition still present, to show the fault sets again. Directed cases apply two sticky flags in the same cycle to separate the priority order from arrival order. One case counts edges to pin down the synchronizer and latch latency. A looped case, with the indicator wired back onto the run request, shows that the block retries on its own.

// File: rtl/amp_fault_pkg.sv
package amp_fault_pkg;
  localparam int SYNC_STAGES = 2;
  localparam int NUM_STICKY  = 3;
  localparam int NUM_SUPPLY  = 2;
  localparam int CAUSE_W     = $clog2(NUM_STICKY + 1);
  localparam int STATUS_W    = CAUSE_W + NUM_STICKY + NUM_SUPPLY;

  typedef enum logic [CAUSE_W-1:0] {
    CAUSE_NONE = 2'd0,
    CAUSE_OC   = 2'd1,
    CAUSE_OT   = 2'd2,
    CAUSE_DC   = 2'd3
  } cause_t;
endpackage

// File: rtl/flag_sync.sv
module flag_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int LAST = STAGES - 1;

  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= '0;
    end else begin
      stage[0] <= d;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign q = stage[LAST];
endmodule

// File: rtl/sticky_fault_latch.sv
module sticky_fault_latch
  import amp_fault_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  run,
  input  logic [NUM_STICKY-1:0] cond,
  output logic [NUM_STICKY-1:0] held,
  output cause_t                first
);
  logic [NUM_STICKY-1:0] held_nxt;
  cause_t                pick;

  // lowest index has priority: overcurrent, then overtemperature, then DC
  always_comb begin
    pick = CAUSE_NONE;
    for (int i = NUM_STICKY - 1; i >= 0; i--) begin
      if (cond[i]) pick = cause_t'(i + 1);
    end
  end

  always_comb begin
    held_nxt = run ? (held | cond) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held  <= '0;
      first <= CAUSE_NONE;
    end else begin
      held <= held_nxt;
      if (!run)                      first <= CAUSE_NONE;
      else if (first == CAUSE_NONE)  first <= pick;
    end
  end

  // R1: a held fault stays held while running
  assert_sticky_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (run && (|held)) |=> (|held));

  // R3: shutdown level wipes every held fault
  assert_shutdown_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run) |=> (held == '0) && (first == CAUSE_NONE));

  // R7: first cause does not move while running
  assert_first_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && first != CAUSE_NONE) |=> $stable(first));
endmodule

// File: rtl/amp_fault_supervisor.sv
module amp_fault_supervisor
  import amp_fault_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run_req,
  input  logic                oc_flag,
  input  logic                ot_flag,
  input  logic                dc_flag,
  input  logic                uv_flag,
  input  logic                ov_flag,
  output logic                out_en,
  output logic                fault_n,
  output logic [STATUS_W-1:0] status
);
  localparam int SYNC_W = 1 + NUM_STICKY + NUM_SUPPLY;

  logic [SYNC_W-1:0]     raw_vec, syn_vec;
  logic                  run_s;
  logic [NUM_STICKY-1:0] sticky_s, held;
  logic [NUM_SUPPLY-1:0] supply_s;
  cause_t                first;

  assign raw_vec = {run_req, oc_flag, ot_flag, dc_flag, uv_flag, ov_flag};

  flag_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw_vec),
    .q     (syn_vec)
  );

  assign run_s    = syn_vec[SYNC_W-1];
  // bit 0 of sticky_s is overcurrent (highest priority)
  assign sticky_s = {syn_vec[NUM_SUPPLY], syn_vec[NUM_SUPPLY+1], syn_vec[NUM_SUPPLY+2]};
  assign supply_s = syn_vec[NUM_SUPPLY-1:0];

  sticky_fault_latch u_latch (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run_s),
    .cond  (sticky_s),
    .held  (held),
    .first (first)
  );

  assign fault_n = ~(|held);
  assign out_en  = run_s & ~(|held) & ~(|sticky_s) & ~(|supply_s);
  assign status  = {first, held[0], held[1], held[2], supply_s};

  // R2: supply faults never touch the indicator while running clean
  assert_supply_no_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_s && (|supply_s) && !(|sticky_s) && fault_n) |=> fault_n);

  // R2: a live supply fault keeps the bridge off
  assert_supply_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|supply_s) |-> !out_en);

  // R5: drive never coexists with a pulled-down indicator
  assert_en_implies_clean_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_en |-> fault_n);

  // R6: a sticky condition seen while running sets the indicator next clock
  assert_resets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run_s && (|sticky_s)) |=> !fault_n);

  // R4: shutdown keeps the bridge off
  assert_shutdown_mutes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_s) |-> !out_en);
endmodule

// File: tb/amp_fault_supervisor_test.sv
`timescale 1ns/1ps
module amp_fault_supervisor_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_run = 1'b0, loop_mode = 1'b0;
  logic oc = 0, ot = 0, dc = 0, uv = 0, ov = 0;
  logic run_req, out_en, fault_n;
  logic [6:0] status;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  assign run_req = loop_mode ? (host_run & fault_n) : host_run;

  amp_fault_supervisor uut (
    .clk(clk), .rst_n(rst_n), .run_req(run_req),
    .oc_flag(oc), .ot_flag(ot), .dc_flag(dc), .uv_flag(uv), .ov_flag(ov),
    .out_en(out_en), .fault_n(fault_n), .status(status)
  );

  // {run, oc, ot, dc, uv, ov, exp_en, exp_fault_n, exp_status[6:0]}
  // status: [6:5] first cause (1 oc,2 ot,3 dc), [4] oc, [3] ot, [2] dc, [1] uv, [0] ov
  localparam int NV = 15;
  localparam logic [14:0] VEC [NV] = '{
    {6'b100000, 2'b11, 7'b0000000},
    {6'b100010, 2'b01, 7'b0000010},
    {6'b100000, 2'b11, 7'b0000000},
    {6'b100001, 2'b01, 7'b0000001},
    {6'b100000, 2'b11, 7'b0000000},
    {6'b101000, 2'b00, 7'b1001000},
    {6'b100000, 2'b00, 7'b1001000},
    {6'b110000, 2'b00, 7'b1011000},
    {6'b000000, 2'b01, 7'b0000000},
    {6'b100000, 2'b11, 7'b0000000},
    {6'b100100, 2'b00, 7'b1100100},
    {6'b000100, 2'b01, 7'b0000000},
    {6'b100100, 2'b00, 7'b1100100},
    {6'b000000, 2'b01, 7'b0000000},
    {6'b100000, 2'b11, 7'b0000000}
  };

  task automatic check(input string req, input logic [8:0] got, input logic [8:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got en/fn/status=%b expected %b", req, got, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #500000;
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: got hung expected completion");
      summary();
    end
  end

  initial begin
    // R11 reset state
    settle(3);
    check("R11 in reset", {out_en, fault_n, status}, {2'b01, 7'd0});
    rst_n = 1'b1;
    settle(1);
    check("R11 after reset", {out_en, fault_n, status}, {2'b01, 7'd0});

    // table: R1 R2 R3 R4 R5 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      {host_run, oc, ot, dc, uv, ov} = VEC[i][14:9];
      settle(4);
      check($sformatf("R1/R2/R3/R4/R5/R6/R7/R8 row %0d", i),
            {out_en, fault_n, status}, VEC[i][8:0]);
    end

    // R9 latency from a clean running state
    oc = 1'b1;
    settle(1);
    check("R9 edge1", {out_en, fault_n, 7'd0}, {2'b11, 7'd0});
    settle(1);
    check("R9 edge2", {out_en, fault_n, 7'd0}, {2'b01, 7'd0});
    settle(1);
    check("R9 edge3", {out_en, fault_n, status}, {2'b00, 7'b0110000});
    oc = 1'b0; host_run = 1'b0; settle(4);
    host_run = 1'b1; settle(4);

    // R7 same-cycle priority
    oc = 1'b1; dc = 1'b1; settle(4);
    check("R7 oc beats dc", {out_en, fault_n, status}, {2'b00, 7'b0110100});
    oc = 1'b0; dc = 1'b0; host_run = 1'b0; settle(4);
    host_run = 1'b1; settle(4);
    ot = 1'b1; dc = 1'b1; settle(4);
    check("R7 ot beats dc", {out_en, fault_n, status}, {2'b00, 7'b1001100});
    ot = 1'b0; dc = 1'b0; host_run = 1'b0; settle(4);
    host_run = 1'b1; settle(4);
    check("R5 back to running", {out_en, fault_n, status}, {2'b11, 7'd0});

    // R10 looped retry
    loop_mode = 1'b1;
    begin
      bit saw = 0, back = 0;
      oc = 1'b1; settle(1); oc = 1'b0;
      for (int k = 0; k < 30; k++) begin
        settle(1);
        if (!fault_n) saw = 1;
        if (saw && fault_n && out_en) back = 1;
      end
      check("R10 self recovery", {saw, back, 7'd0}, {2'b11, 7'd0});
      check("R10 final state", {out_en, fault_n, status}, {2'b11, 7'd0});
    end
    loop_mode = 1'b0;

    finished = 1;
    summary();
  end
endmodule